// File: doc/BRIEF.md
# Per-Port Statistics Update Engine

This block keeps the management counters of a multi-port repeater in a byte-wide SRAM. Upstream logic hands it one checked status record per received frame. The record carries the repeater select, the port number, the octet count, the error and event flags, and the frame's source address. The engine sorts the record into the counters that repeater management rules say it affects. It then updates each counter in memory by read-modify-write.

For frames that qualify as readable, the engine compares the incoming source address with the 48-bit address stored for the port. If they differ, it counts a change, raises a mismatch pulse and stores the new address. Each counter it touches sets a bit in one of two per-port change-status bytes in memory. A counter whose low byte carries out is reported on an overflow pulse, together with an attribute code and the repeater/port location.

Records enter through a valid/ready pair. Ready is high only while the engine is idle, and a record is taken on a cycle where both are high. The upstream side keeps the record stable and valid until it is taken, so it can hold one pending record while the previous frame is still being processed. Memory is reached through a request/grant port towards an arbiter.

Top module: `stat_update_engine`

## Requirements
- R1: A record whose octet count lies in 64..1518 inclusive, with neither FCS error (flag bit 0) nor collision (flag bit 2), is readable. It adds 1 to the readable-frame counter (code 0x01) and adds the octet count to the readable-octet counter (code 0x02).
- R2: The FCS-error counter (code 0x03) adds 1 when the FCS error flag is set, the framing error flag (bit 1) and the collision flag are clear, and the length is in 64..1518.
- R3: The alignment counter (code 0x04) adds 1 when the FCS and framing error flags are both set, the collision flag is clear, and the length is in 64..1518.
- R4: The too-long counter (code 0x05) adds 1 when the octet count exceeds 1518 and the FCS error flag is clear. A record that matches no rule leaves memory unchanged.
- R5: Event counters add 1 as follows: short event (code 0x06) on flag bit 3; runt (0x07) on flag bit 4 with no collision; collision (0x08) on flag bit 2; late event (0x09) on flag bit 5; very long (0x0A) on flag bit 6; rate mismatch (0x0B) on flag bit 7 with no collision and length of at least 64.
- R6: For a readable record, the 48-bit address at page offsets 48..53 (least significant byte first) is compared with the record's address. On a difference, the change counter (code 0x0C) adds 1, `sa_mismatch_irq` pulses for one cycle and the stored address is replaced. No other record touches it.
- R7: Each counter is 32 bits, stored least significant byte first at page offset 4*(code-1). The carry ripples upward, and only bytes whose value changes are written.
- R8: When an addition carries out of a counter's low byte, `ovf_valid` pulses for one cycle with `ovf_code` holding the attribute code and `ovf_loc` holding {repeater, port}.
- R9: Status byte 1 at offset 56 gains, by OR, bits 7..0 = late, collision, runt, short, too long, alignment, FCS, readable. Status byte 2 at offset 57 gains bits 2..0 = address change, rate mismatch, very long. Bits already set stay set.
- R10: `rec_ready` is high only when idle and drops in the cycle after a record is taken. A memory request holds address, direction and write data until granted, and read data is taken in the cycle after the grant.
- R11: The memory address is {repeater, port, 6-bit offset}. No location outside the record's page is written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| rec_valid | input | 1 | Record offered |
| rec_ready | output | 1 | Engine idle, record will be taken |
| rec_rep | input | 1 | Repeater select |
| rec_port | input | PORT_W | Port number |
| rec_octets | input | LEN_W | Frame octet count |
| rec_flags | input | 8 | Flags: 0 FCS, 1 framing, 2 collision, 3 short, 4 runt, 5 late, 6 very long, 7 rate mismatch |
| rec_sa | input | 48 | Source address |
| mem_req | output | 1 | Memory request |
| mem_gnt | input | 1 | Memory grant |
| mem_we | output | 1 | 1 write, 0 read |
| mem_addr | output | PORT_W+7 | Byte address |
| mem_wdata | output | 8 | Write byte |
| mem_rdata | input | 8 | Read byte, valid the cycle after a granted read |
| sa_mismatch_irq | output | 1 | Source address change pulse |
| ovf_valid | output | 1 | Counter low-byte carry pulse |
| ovf_code | output | 8 | Attribute code of the overflow |
| ovf_loc | output | PORT_W+1 | {repeater, port} of the overflow |

## Verification
The properties assume that the arbiter may hold `mem_gnt` low for any number of cycles, that a granted read returns its byte exactly one cycle later, and that no other agent changes the page while a record is in progress. The bench's memory model returns data on the cycle after a grant. Half of the table runs with a pseudo-random grant that stalls requests. Memory is preloaded only while `rec_ready` is high, and a record is held on the inputs until it has been taken.

// File: rtl/stat_pkg.sv
package stat_pkg;
  localparam int OFF_W     = 6;
  localparam int CNT_BYTES = 4;
  localparam int SA_BYTES  = 6;
  localparam int N_ATTR    = 12;
  localparam int SA_BASE   = 48;
  localparam int STAT_BASE = 56;
  localparam int PAGE_USED = 58;

  localparam logic [3:0] ATTR_FRAMES = 4'd1;
  localparam logic [3:0] ATTR_OCTETS = 4'd2;
  localparam logic [3:0] ATTR_ADDRCH = 4'd12;

  typedef enum logic [3:0] {
    S_IDLE, S_SA_RD, S_SA_RW, S_SA_WR,
    S_CNT_NEXT, S_CNT_CHK, S_CNT_RD, S_CNT_RW, S_CNT_WR,
    S_ST_CHK, S_ST_RD, S_ST_RW, S_ST_WR
  } eng_state_t;
endpackage

// File: rtl/stat_classify.sv
module stat_classify import stat_pkg::*; #(
  parameter int LEN_W   = 16,
  parameter int MIN_LEN = 64,
  parameter int MAX_LEN = 1518
) (
  input  logic [LEN_W-1:0]  octets,
  input  logic [7:0]        flags,
  output logic [N_ATTR-2:0] hit
);
  localparam logic [LEN_W-1:0] MIN_V = LEN_W'(MIN_LEN);
  localparam logic [LEN_W-1:0] MAX_V = LEN_W'(MAX_LEN);

  logic fcs, frm, col, in_win, readable;

  always_comb begin
    fcs      = flags[0];
    frm      = flags[1];
    col      = flags[2];
    in_win   = (octets >= MIN_V) && (octets <= MAX_V);
    readable = in_win && !fcs && !col;
    hit[0]   = readable;
    hit[1]   = readable;
    hit[2]   = fcs && !frm && !col && in_win;
    hit[3]   = fcs && frm && !col && in_win;
    hit[4]   = (octets > MAX_V) && !fcs;
    hit[5]   = flags[3];
    hit[6]   = flags[4] && !col;
    hit[7]   = col;
    hit[8]   = flags[5];
    hit[9]   = flags[6];
    hit[10]  = flags[7] && !col && (octets >= MIN_V);
  end
endmodule

// File: rtl/stat_byte_add.sv
module stat_byte_add (
  input  logic [7:0] a,
  input  logic [7:0] b,
  input  logic       cin,
  output logic [7:0] sum,
  output logic       cout
);
  always_comb begin
    {cout, sum} = {1'b0, a} + {1'b0, b} + {8'b0, cin};
  end
endmodule

// File: rtl/stat_status_map.sv
module stat_status_map import stat_pkg::*; (
  input  logic [N_ATTR-1:0] mask,
  input  logic              sel_second,
  output logic [7:0]        bits
);
  logic [7:0] first_b, second_b;

  always_comb begin
    first_b[0] = mask[0] | mask[1];
    second_b   = {5'b0, mask[11], mask[10], mask[9]};
  end

  for (genvar g = 1; g < 8; g++) begin : g_first
    assign first_b[g] = mask[g+1];
  end

  assign bits = sel_second ? second_b : first_b;
endmodule

// File: rtl/stat_update_engine.sv
module stat_update_engine import stat_pkg::*; #(
  parameter int PORT_W  = 4,
  parameter int LEN_W   = 16,
  parameter int MIN_LEN = 64,
  parameter int MAX_LEN = 1518
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    rec_valid,
  output logic                    rec_ready,
  input  logic                    rec_rep,
  input  logic [PORT_W-1:0]       rec_port,
  input  logic [LEN_W-1:0]        rec_octets,
  input  logic [7:0]              rec_flags,
  input  logic [47:0]             rec_sa,
  output logic                    mem_req,
  input  logic                    mem_gnt,
  output logic                    mem_we,
  output logic [PORT_W+OFF_W:0]   mem_addr,
  output logic [7:0]              mem_wdata,
  input  logic [7:0]              mem_rdata,
  output logic                    sa_mismatch_irq,
  output logic                    ovf_valid,
  output logic [7:0]              ovf_code,
  output logic [PORT_W:0]         ovf_loc
);
  localparam int CNT_W = CNT_BYTES * 8;

  eng_state_t          state;
  logic                rep_q;
  logic [PORT_W-1:0]   port_q;
  logic [LEN_W-1:0]    oct_q;
  logic [47:0]         sa_q;
  logic [N_ATTR-1:0]   mask;
  logic [3:0]          code;
  logic [2:0]          bidx;
  logic                carry;
  logic                sa_diff;
  logic                st_idx;
  logic [7:0]          wbyte;

  logic [N_ATTR-2:0]   hit;
  logic [CNT_W-1:0]    add_full;
  logic [7:0]          cur_add;
  logic                rest_nz;
  logic [7:0]          add_sum;
  logic                add_cout;
  logic [7:0]          st_bits;
  logic [7:0]          sa_byte;
  logic                byte_ne;
  logic [3:0]          code_m1;
  logic [OFF_W-1:0]    ctr_off;
  logic [OFF_W-1:0]    off;

  stat_classify #(.LEN_W(LEN_W), .MIN_LEN(MIN_LEN), .MAX_LEN(MAX_LEN)) u_cls (
    .octets(rec_octets), .flags(rec_flags), .hit(hit)
  );

  stat_byte_add u_add (
    .a(mem_rdata), .b(cur_add), .cin(carry), .sum(add_sum), .cout(add_cout)
  );

  stat_status_map u_map (
    .mask(mask), .sel_second(st_idx), .bits(st_bits)
  );

  always_comb begin
    add_full = (code == ATTR_OCTETS) ? CNT_W'(oct_q) : CNT_W'(1);
    cur_add  = add_full[{bidx[1:0], 3'b000} +: 8];
    rest_nz  = |(add_full >> {bidx, 3'b000});
    sa_byte  = sa_q[{bidx, 3'b000} +: 8];
    byte_ne  = (mem_rdata != sa_byte);
    code_m1  = code - 4'd1;
    ctr_off  = {code_m1, bidx[1:0]};
  end

  always_comb begin
    mem_req   = 1'b0;
    mem_we    = 1'b0;
    off       = '0;
    mem_wdata = '0;
    case (state)
      S_SA_RD:  begin mem_req = 1'b1; off = OFF_W'(SA_BASE) + OFF_W'(bidx); end
      S_SA_WR:  begin
        mem_req = 1'b1; mem_we = 1'b1;
        off = OFF_W'(SA_BASE) + OFF_W'(bidx); mem_wdata = sa_byte;
      end
      S_CNT_RD: begin mem_req = 1'b1; off = ctr_off; end
      S_CNT_WR: begin mem_req = 1'b1; mem_we = 1'b1; off = ctr_off; mem_wdata = wbyte; end
      S_ST_RD:  begin mem_req = 1'b1; off = OFF_W'(STAT_BASE) + OFF_W'(st_idx); end
      S_ST_WR:  begin
        mem_req = 1'b1; mem_we = 1'b1;
        off = OFF_W'(STAT_BASE) + OFF_W'(st_idx); mem_wdata = wbyte;
      end
      default: ;
    endcase
    mem_addr = {rep_q, port_q, off};
  end

  assign rec_ready = (state == S_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state           <= S_IDLE;
      rep_q           <= 1'b0;
      port_q          <= '0;
      oct_q           <= '0;
      sa_q            <= '0;
      mask            <= '0;
      code            <= '0;
      bidx            <= '0;
      carry           <= 1'b0;
      sa_diff         <= 1'b0;
      st_idx          <= 1'b0;
      wbyte           <= '0;
      sa_mismatch_irq <= 1'b0;
      ovf_valid       <= 1'b0;
      ovf_code        <= '0;
      ovf_loc         <= '0;
    end else begin
      sa_mismatch_irq <= 1'b0;
      ovf_valid       <= 1'b0;
      case (state)
        S_IDLE: begin
          if (rec_valid) begin
            rep_q   <= rec_rep;
            port_q  <= rec_port;
            oct_q   <= rec_octets;
            sa_q    <= rec_sa;
            mask    <= {1'b0, hit};
            sa_diff <= 1'b0;
            bidx    <= '0;
            code    <= '0;
            state   <= hit[0] ? S_SA_RD : S_CNT_NEXT;
          end
        end
        S_SA_RD: if (mem_gnt) state <= S_SA_RW;
        S_SA_RW: begin
          if (bidx == 3'(SA_BYTES - 1)) begin
            if (sa_diff || byte_ne) begin
              mask[N_ATTR-1]  <= 1'b1;
              sa_mismatch_irq <= 1'b1;
              bidx            <= '0;
              state           <= S_SA_WR;
            end else begin
              state <= S_CNT_NEXT;
            end
          end else begin
            sa_diff <= sa_diff | byte_ne;
            bidx    <= bidx + 3'd1;
            state   <= S_SA_RD;
          end
        end
        S_SA_WR: begin
          if (mem_gnt) begin
            if (bidx == 3'(SA_BYTES - 1)) state <= S_CNT_NEXT;
            else bidx <= bidx + 3'd1;
          end
        end
        S_CNT_NEXT: begin
          if (code == 4'(N_ATTR)) begin
            st_idx <= 1'b0;
            state  <= S_ST_CHK;
          end else begin
            code <= code + 4'd1;
            if (mask[code]) begin
              bidx  <= '0;
              carry <= 1'b0;
              state <= S_CNT_CHK;
            end
          end
        end
        S_CNT_CHK: begin
          if (bidx == 3'(CNT_BYTES)) begin
            state <= S_CNT_NEXT;
          end else if (!carry && cur_add == 8'd0) begin
            if (rest_nz) bidx <= bidx + 3'd1;
            else state <= S_CNT_NEXT;
          end else begin
            state <= S_CNT_RD;
          end
        end
        S_CNT_RD: if (mem_gnt) state <= S_CNT_RW;
        S_CNT_RW: begin
          carry <= add_cout;
          wbyte <= add_sum;
          if (bidx == 3'd0 && add_cout) begin
            ovf_valid <= 1'b1;
            ovf_code  <= {4'b0, code};
            ovf_loc   <= {rep_q, port_q};
          end
          state <= S_CNT_WR;
        end
        S_CNT_WR: begin
          if (mem_gnt) begin
            bidx  <= bidx + 3'd1;
            state <= S_CNT_CHK;
          end
        end
        S_ST_CHK: begin
          if (st_bits == 8'd0) begin
            if (st_idx) state <= S_IDLE;
            else st_idx <= 1'b1;
          end else begin
            state <= S_ST_RD;
          end
        end
        S_ST_RD: if (mem_gnt) state <= S_ST_RW;
        S_ST_RW: begin
          wbyte <= mem_rdata | st_bits;
          state <= S_ST_WR;
        end
        S_ST_WR: begin
          if (mem_gnt) begin
            if (st_idx) state <= S_IDLE;
            else begin
              st_idx <= 1'b1;
              state  <= S_ST_CHK;
            end
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/stat_update_engine_chk.sv
module stat_update_engine_chk import stat_pkg::*; #(
  parameter int PORT_W = 4
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  rec_valid,
  input logic                  rec_ready,
  input logic                  mem_req,
  input logic                  mem_gnt,
  input logic                  mem_we,
  input logic [PORT_W+OFF_W:0] mem_addr,
  input logic [7:0]            mem_wdata,
  input logic                  sa_mismatch_irq,
  input logic                  ovf_valid,
  input logic [7:0]            ovf_code
);
  p_req_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_gnt |=> mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata));

  p_accept_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rec_valid && rec_ready |=> !rec_ready);

  p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rec_ready |-> !mem_req);

  p_ovf_code_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_valid |-> (ovf_code >= 8'd1) && (ovf_code <= 8'(N_ATTR)));

  p_ovf_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_valid |-> !rec_ready);

  p_page_range_r11: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> (mem_addr[OFF_W-1:0] < OFF_W'(PAGE_USED)));

  p_addr_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
    sa_mismatch_irq |-> mem_req && mem_we && (mem_addr[OFF_W-1:0] == OFF_W'(SA_BASE)));
endmodule

bind stat_update_engine stat_update_engine_chk #(.PORT_W(PORT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .rec_valid(rec_valid), .rec_ready(rec_ready),
  .mem_req(mem_req), .mem_gnt(mem_gnt), .mem_we(mem_we), .mem_addr(mem_addr),
  .mem_wdata(mem_wdata), .sa_mismatch_irq(sa_mismatch_irq),
  .ovf_valid(ovf_valid), .ovf_code(ovf_code)
);

// File: tb/stat_update_engine_bench.sv
module stat_update_engine_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rec_valid = 1'b0;
  logic        rec_ready;
  logic        rec_rep = 1'b0;
  logic [3:0]  rec_port = '0;
  logic [15:0] rec_octets = '0;
  logic [7:0]  rec_flags = '0;
  logic [47:0] rec_sa = '0;
  logic        mem_req, mem_gnt, mem_we;
  logic [10:0] mem_addr;
  logic [7:0]  mem_wdata;
  logic [7:0]  mem_rdata;
  logic        sa_mismatch_irq, ovf_valid;
  logic [7:0]  ovf_code;
  logic [4:0]  ovf_loc;

  always #5 clk = ~clk;

  stat_update_engine u_stat_update_engine (
    .clk(clk), .rst_n(rst_n), .rec_valid(rec_valid), .rec_ready(rec_ready),
    .rec_rep(rec_rep), .rec_port(rec_port), .rec_octets(rec_octets),
    .rec_flags(rec_flags), .rec_sa(rec_sa), .mem_req(mem_req), .mem_gnt(mem_gnt),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .sa_mismatch_irq(sa_mismatch_irq), .ovf_valid(ovf_valid), .ovf_code(ovf_code),
    .ovf_loc(ovf_loc)
  );

  // Memory model, pokes, grant stall generator and pulse monitors
  logic [7:0]  mem [2048];
  logic [7:0]  exp_mem [2048];
  logic [7:0]  lfsr;
  logic        gnt_rand = 1'b0;
  logic        pre_we = 1'b0;
  logic [10:0] pre_addr = '0;
  logic [7:0]  pre_data = '0;
  int wr_cnt = 0, ovf_seen = 0, sa_seen = 0, acc_cnt = 0;
  logic [7:0]  ovf_last_code = '0;
  logic [4:0]  ovf_last_loc = '0;

  assign mem_gnt = gnt_rand ? lfsr[0] : 1'b1;

  always @(posedge clk) begin
    if (!rst_n) begin
      lfsr <= 8'h5A;
      mem_rdata <= '0;
      for (int i = 0; i < 2048; i++) mem[i] <= '0;
    end else begin
      lfsr <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      if (pre_we) mem[pre_addr] <= pre_data;
      if (mem_req && mem_gnt) begin
        if (mem_we) begin mem[mem_addr] <= mem_wdata; wr_cnt <= wr_cnt + 1; end
        else mem_rdata <= mem[mem_addr];
      end
      if (ovf_valid) begin
        ovf_seen <= ovf_seen + 1; ovf_last_code <= ovf_code; ovf_last_loc <= ovf_loc;
      end
      if (sa_mismatch_irq) sa_seen <= sa_seen + 1;
      if (rec_valid && rec_ready) acc_cnt <= acc_cnt + 1;
    end
  end

  int checks = 0, errors = 0, exp_ovf = 0, exp_sa = 0;
  logic [7:0] exp_last_code;
  bit done = 0;

  task automatic chk(input bit ok, input string msg, input logic [63:0] act, input logic [63:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", msg, act, expv);
    end
  endtask

  task automatic poke(input logic [10:0] a, input logic [7:0] d);
    @(negedge clk); pre_we = 1'b1; pre_addr = a; pre_data = d;
    @(negedge clk); pre_we = 1'b0;
    exp_mem[a] = d;
  endtask

  // Reference model built from R1..R9, applied to exp_mem
  task automatic model_apply(input logic [76:0] r);
    logic rep; logic [3:0] port; logic [15:0] oct; logic [7:0] f; logic [47:0] sa;
    logic [12:1] m; logic win, rd; logic [31:0] v, addv; int base;
    logic [7:0] s1, s2;
    rep = r[76]; port = r[75:72]; oct = r[71:56]; f = r[55:48]; sa = r[47:0];
    base = {rep, port, 6'd0};
    win = (oct >= 16'd64) && (oct <= 16'd1518);
    rd  = win && !f[0] && !f[2];
    m[1] = rd; m[2] = rd;
    m[3] = f[0] && !f[1] && !f[2] && win;
    m[4] = f[0] && f[1] && !f[2] && win;
    m[5] = (oct > 16'd1518) && !f[0];
    m[6] = f[3]; m[7] = f[4] && !f[2]; m[8] = f[2]; m[9] = f[5]; m[10] = f[6];
    m[11] = f[7] && !f[2] && (oct >= 16'd64);
    m[12] = 1'b0;
    if (rd) begin
      for (int k = 0; k < 6; k++) if (exp_mem[base + 48 + k] != sa[8*k +: 8]) m[12] = 1'b1;
      if (m[12]) begin
        exp_sa++;
        for (int k = 0; k < 6; k++) exp_mem[base + 48 + k] = sa[8*k +: 8];
      end
    end
    for (int c = 1; c <= 12; c++) begin
      if (m[c]) begin
        addv = (c == 2) ? {16'd0, oct} : 32'd1;
        for (int k = 0; k < 4; k++) v[8*k +: 8] = exp_mem[base + 4*(c-1) + k];
        if ({1'b0, v[7:0]} + {1'b0, addv[7:0]} > 9'd255) begin
          exp_ovf++; exp_last_code = 8'(c);
        end
        v = v + addv;
        for (int k = 0; k < 4; k++) exp_mem[base + 4*(c-1) + k] = v[8*k +: 8];
      end
    end
    s1 = {m[9], m[8], m[7], m[6], m[5], m[4], m[3], m[1] | m[2]};
    s2 = {5'd0, m[12], m[11], m[10]};
    exp_mem[base + 56] = exp_mem[base + 56] | s1;
    exp_mem[base + 57] = exp_mem[base + 57] | s2;
  endtask

  task automatic drive(input logic [76:0] r);
    rec_rep = r[76]; rec_port = r[75:72]; rec_octets = r[71:56];
    rec_flags = r[55:48]; rec_sa = r[47:0];
  endtask

  task automatic send(input logic [76:0] r);
    @(negedge clk); drive(r); rec_valid = 1'b1;
    while (!rec_ready) @(negedge clk);
    @(negedge clk); rec_valid = 1'b0;
    chk(rec_ready == 1'b0, "R10 ready low after accept", 64'(rec_ready), 64'd0);
    while (!rec_ready) @(negedge clk);
    model_apply(r);
  endtask

  task automatic check_page(input logic rep, input logic [3:0] port, input string tag);
    int bad = -1;
    for (int k = 0; k < 58; k++)
      if (bad < 0 && mem[{rep, port, 6'(k)}] !== exp_mem[{rep, port, 6'(k)}]) bad = k;
    if (bad < 0) chk(1'b1, tag, 0, 0);
    else chk(1'b0, $sformatf("%s page offset %0d", tag, bad),
             64'(mem[{rep, port, 6'(bad)}]), 64'(exp_mem[{rep, port, 6'(bad)}]));
  endtask

  // flags: 0 fcs, 1 framing, 2 collision, 3 short, 4 runt, 5 late, 6 very long, 7 rate
  localparam logic [76:0] VEC [12] = '{
    {1'b0, 4'd3,  16'd100,  8'h00, 48'h0A0B0C0D0E0F},
    {1'b0, 4'd3,  16'd64,   8'h00, 48'h0A0B0C0D0E0F},
    {1'b1, 4'd13, 16'd1518, 8'h01, 48'h111111111111},
    {1'b1, 4'd13, 16'd200,  8'h03, 48'h000000000001},
    {1'b0, 4'd3,  16'd1519, 8'h00, 48'h000000000002},
    {1'b0, 4'd3,  16'd1519, 8'h01, 48'h000000000003},
    {1'b0, 4'd0,  16'd63,   8'h08, 48'h000000000004},
    {1'b0, 4'd0,  16'd40,   8'h14, 48'h000000000005},
    {1'b1, 4'd5,  16'd500,  8'hE4, 48'h000000000006},
    {1'b1, 4'd5,  16'd300,  8'h80, 48'hA1A2A3A4A5A6},
    {1'b0, 4'd3,  16'd1000, 8'h05, 48'h000000000007},
    {1'b0, 4'd3,  16'd100,  8'h00, 48'hC0C1C2C3C4C5}
  };
  localparam string VTAG [12] = '{
    "R1 readable frame", "R1 length at minimum", "R2 fcs at maximum length",
    "R3 alignment error", "R4 too long", "R4 long with fcs ignored",
    "R5 short event", "R5 runt suppressed by collision", "R5 late collision very long",
    "R5 rate mismatch with R6 change", "R5 collision only", "R6 second address change"
  };

  initial begin
    int o0, w0, a0;
    for (int i = 0; i < 2048; i++) exp_mem[i] = '0;
    repeat (3) @(negedge clk);
    chk(rec_ready == 1'b1, "R10 reset ready", 64'(rec_ready), 1);
    chk(mem_req == 1'b0, "R10 reset no request", 64'(mem_req), 0);
    chk(ovf_valid == 1'b0 && sa_mismatch_irq == 1'b0, "R8 reset pulses low",
        64'({ovf_valid, sa_mismatch_irq}), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    for (int i = 0; i < 12; i++) begin
      gnt_rand = (i >= 6);
      send(VEC[i]);
      check_page(VEC[i][76], VEC[i][75:72], VTAG[i]);
    end
    gnt_rand = 1'b0;

    // R8 low-byte wrap of readable-frame counter
    poke({1'b0, 4'd7, 6'd0}, 8'hFF);
    o0 = ovf_seen;
    send({1'b0, 4'd7, 16'd100, 8'h00, 48'h123456789ABC});
    chk(ovf_seen == o0 + 1, "R8 one overflow pulse", 64'(ovf_seen - o0), 1);
    chk(ovf_last_code == 8'h01, "R8 overflow code frames", 64'(ovf_last_code), 1);
    chk(ovf_last_loc == 5'h07, "R8 overflow location", 64'(ovf_last_loc), 7);
    check_page(1'b0, 4'd7, "R7 carry into second byte");

    // R7 carry ripples through all octet-counter bytes
    for (int k = 0; k < 4; k++) poke({1'b1, 4'd2, 6'(4 + k)}, 8'hFF);
    for (int k = 0; k < 6; k++) poke({1'b1, 4'd2, 6'(48 + k)}, 8'h77);
    o0 = ovf_seen; a0 = sa_seen;
    send({1'b1, 4'd2, 16'd64, 8'h00, 48'h777777777777});
    chk(ovf_last_code == 8'h02 && ovf_seen == o0 + 1, "R8 octet overflow code",
        64'(ovf_last_code), 2);
    chk(ovf_last_loc == 5'h12, "R8 octet overflow location", 64'(ovf_last_loc), 64'h12);
    chk(sa_seen == a0, "R6 equal address no pulse", 64'(sa_seen - a0), 0);
    check_page(1'b1, 4'd2, "R7 full ripple");

    // R7 minimal writes and R9 status OR merge
    poke({1'b0, 4'd9, 6'd28}, 8'h05);
    poke({1'b0, 4'd9, 6'd56}, 8'h80);
    w0 = wr_cnt;
    send({1'b0, 4'd9, 16'd30, 8'h04, 48'h0});
    chk(wr_cnt - w0 == 2, "R7 only changed bytes written", 64'(wr_cnt - w0), 2);
    chk(mem[{1'b0, 4'd9, 6'd56}] == 8'hC0, "R9 status bits kept and merged",
        64'(mem[{1'b0, 4'd9, 6'd56}]), 64'hC0);
    check_page(1'b0, 4'd9, "R9 page after merge");

    // R10 back-to-back: second record held valid while busy
    a0 = acc_cnt;
    gnt_rand = 1'b1;
    @(negedge clk); drive({1'b0, 4'd11, 16'd700, 8'h00, 48'hAB}); rec_valid = 1'b1;
    while (!rec_ready) @(negedge clk);
    @(negedge clk); drive({1'b0, 4'd11, 16'd80, 8'h08, 48'hAB});
    model_apply({1'b0, 4'd11, 16'd700, 8'h00, 48'hAB});
    while (!rec_ready) @(negedge clk);
    @(negedge clk); rec_valid = 1'b0;
    while (!rec_ready) @(negedge clk);
    model_apply({1'b0, 4'd11, 16'd80, 8'h08, 48'hAB});
    gnt_rand = 1'b0;
    chk(acc_cnt - a0 == 2, "R10 one acceptance per record", 64'(acc_cnt - a0), 2);
    check_page(1'b0, 4'd11, "R10 held record processed");

    // Totals and stray writes
    chk(ovf_seen == exp_ovf, "R8 overflow pulse total", 64'(ovf_seen), 64'(exp_ovf));
    chk(sa_seen == exp_sa, "R6 mismatch pulse total", 64'(sa_seen), 64'(exp_sa));
    begin
      int bad = -1;
      for (int i = 0; i < 2048; i++) if (bad < 0 && mem[i] !== exp_mem[i]) bad = i;
      chk(bad < 0, "R11 no writes outside record pages", 64'(bad), 64'hFFFFFFFFFFFFFFFF);
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog R10 actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule